// File: doc/BRIEF.md
# Rate-Corrected Nanosecond Time Counter with Periodic Pulse Outputs

This block keeps a 64-bit time of day in nanoseconds for precision time protocols. It runs from a reference oscillator, but the time value does not advance on every reference clock. A 32-bit phase accumulator adds a programmable addend on every running clock. Each carry out of its top bit is one nominal tick, and on each tick the time value grows by a programmed nominal period in nanoseconds. Software trims the rate by changing the addend. The addend is chosen as the ceiling of 2^32 divided by the ratio of reference frequency to nominal frequency. That ratio must be above one, so the addend always stays below 2^32.

Two more functions follow the same ticks. The first is a prescaled output clock, whose period is the prescale count times the nominal period. The second is a set of periodic pulse generators. Each generator is loaded with an interval of `prescale × period × divider − period` nanoseconds and fires once per `interval + period` nanoseconds of counter time. The pulse lasts one output clock period. Generator 0 is normally set up for a one pulse per second output. A 2-bit reference source code is held and driven out for the clock multiplexer outside this block. Its codes are 0 external precision clock, 1 system clock, 2 port transmit clock and 3 real-time clock input.

Top module: `tstamp_timer`

## Requirements
- R1: After synchronous reset, `tod_o` is 0, `out_clk_o` and every `pulse_o` bit are 0, and `ref_sel_o` is 1. The configuration reads addend 0, period 0, prescale 1, intervals 0 and run 0.
- R2: While run is set, a 32-bit accumulator adds the addend on every clock, and each carry out of bit 31 is one tick. With addend 0x999999A4 and the accumulator starting at 0, 3000 running clocks give exactly 1800 ticks, and every 3 consecutive clocks hold 1 or 2 ticks.
- R3: On each tick `tod_o` grows by the period register. Without a tick or a time load it holds its value.
- R4: A configuration write to address 0 (addend) applies from the clock after the write edge. It clears neither the accumulator nor the time value.
- R5: The output clock counts ticks from 0 to prescale−1 (a prescale of 0 acts as 1). It is high while the count is below floor(prescale/2). Its rising edges are therefore prescale×period ns of counter time apart, and a prescale of 1 keeps it low.
- R6: Each pulse generator decrements its count by the period on every tick. When the count is below the period, it fires and reloads its interval. Rising edges are then interval+period ns of counter time apart.
- R7: A pulse stays high for prescale ticks, which is prescale×period ns of counter time.
- R8: While run is 0, the accumulator, `tod_o`, `out_clk_o` and `pulse_o` do not change.
- R9: A pulse on `time_we` loads `time_wdata` into `tod_o` at that edge. It also resets the prescaler count to 0, reloads each pulse count with its interval and drives all pulses low. The first later pulse i rises at loaded value + interval_i + period.
- R10: `tod_o` wraps modulo 2^64.
- R11: With period 100 000 000, prescale 1 and interval 900 000 000, pulse 0 rises at exactly every 10^9 ns of counter time, the first one at load value + 10^9.
- R12: Configuration address 3 is the control word: bit 0 is run and bits 2:1 are the reference source. `ref_sel_o` follows bits 2:1 at the next edge, whatever the value of run. Addresses 1 and 2 hold period and prescale, and address 4+i holds the interval of generator i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | CFG_W | Configuration write data |
| time_we | input | 1 | Load strobe for the time value |
| time_wdata | input | TOD_W | New time value in ns |
| tod_o | output | TOD_W | Current time in ns |
| out_clk_o | output | 1 | Prescaled output clock |
| pulse_o | output | NUM_PULSE | Periodic pulse outputs |
| ref_sel_o | output | 2 | Reference source code |

## Verification
The hardest situation to reach is the phase relation between the pulse generators and the time value after a restart. Counts that are left over from an earlier configuration, or that start from zero, fire early and hide a wrong reload. The stimulus therefore writes every interval with run cleared, loads a known time, and only then sets run. It records the counter time of each first edge and checks it against the loaded value. An addend change is made in the middle of a run, so the leftover accumulator phase carries over. A cycle-by-cycle arithmetic model of the time value shows any reset or delay of the accumulator.

// File: rtl/tst_pkg.sv
`timescale 1ns/1ps
package tst_pkg;
  // configuration address map
  localparam int unsigned ADDR_ADDEND   = 0;
  localparam int unsigned ADDR_PERIOD   = 1;
  localparam int unsigned ADDR_PRESCALE = 2;
  localparam int unsigned ADDR_CTRL     = 3;
  localparam int unsigned IVL_BASE      = 4;
  // control word fields
  localparam int unsigned CTRL_RUN      = 0;
  localparam int unsigned CTRL_SEL_LSB  = 1;
  localparam int unsigned SEL_W         = 2;

  typedef enum logic [SEL_W-1:0] {
    REF_EXT_PRECISE = 2'd0,
    REF_SYSTEM      = 2'd1,
    REF_PORT_TX     = 2'd2,
    REF_RTC_IN      = 2'd3
  } ref_src_e;
endpackage

// File: rtl/tst_rate_acc.sv
`timescale 1ns/1ps
module tst_rate_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [ACC_W-1:0] addend,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum  = {1'b0, acc_q} + {1'b0, addend};
  assign tick = run & sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '0;
    else if (run)
      acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/tst_tod.sv
`timescale 1ns/1ps
module tst_tod #(
  parameter int TOD_W = 64,
  parameter int PER_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  input  logic             load,
  input  logic [TOD_W-1:0] load_val,
  output logic [TOD_W-1:0] tod_q
);
  localparam int PAD_W = TOD_W - PER_W;

  logic [TOD_W-1:0] step;
  assign step = {{PAD_W{1'b0}}, period};

  always_ff @(posedge clk) begin
    if (rst)
      tod_q <= '0;
    else if (load)
      tod_q <= load_val;
    else if (tick)
      tod_q <= tod_q + step;
  end
endmodule

// File: rtl/tst_prescaler.sv
`timescale 1ns/1ps
module tst_prescaler #(
  parameter int PS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            restart,
  input  logic [PS_W-1:0] prescale,
  output logic            out_clk_o
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] eff;
  logic [PS_W-1:0] half;
  logic [PS_W-1:0] nxt;

  assign eff  = (prescale == '0) ? PS_W'(1) : prescale;
  assign half = eff >> 1;
  assign nxt  = (cnt_q >= eff - PS_W'(1)) ? '0 : cnt_q + PS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      out_clk_o <= 1'b0;
    end else if (restart) begin
      cnt_q     <= '0;
      out_clk_o <= (half != '0);
    end else if (tick) begin
      cnt_q     <= nxt;
      out_clk_o <= (nxt < half);
    end
  end
endmodule

// File: rtl/tst_pulse_gen.sv
`timescale 1ns/1ps
module tst_pulse_gen #(
  parameter int CNT_W = 32,
  parameter int PS_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] interval,
  input  logic [CNT_W-1:0] period,
  input  logic [PS_W-1:0]  prescale,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PS_W-1:0]  wleft_q;
  logic [PS_W-1:0]  width_m1;
  logic             fire;

  assign fire     = (cnt_q < period);
  assign width_m1 = (prescale == '0) ? '0 : prescale - PS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      wleft_q <= '0;
      pulse_o <= 1'b0;
    end else if (restart) begin
      cnt_q   <= interval;
      wleft_q <= '0;
      pulse_o <= 1'b0;
    end else if (tick) begin
      if (fire) begin
        cnt_q   <= interval;
        wleft_q <= width_m1;
        pulse_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q - period;
        if (pulse_o) begin
          if (wleft_q == '0)
            pulse_o <= 1'b0;
          else
            wleft_q <= wleft_q - PS_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/tstamp_timer.sv
`timescale 1ns/1ps
module tstamp_timer #(
  parameter int ADDR_W    = 3,
  parameter int CFG_W     = 32,
  parameter int TOD_W     = 64,
  parameter int PS_W      = 16,
  parameter int NUM_PULSE = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 time_we,
  input  logic [TOD_W-1:0]     time_wdata,
  output logic [TOD_W-1:0]     tod_o,
  output logic                 out_clk_o,
  output logic [NUM_PULSE-1:0] pulse_o,
  output logic [1:0]           ref_sel_o
);
  import tst_pkg::*;

  logic [CFG_W-1:0] addend_q;
  logic [CFG_W-1:0] period_q;
  logic [PS_W-1:0]  prescale_q;
  logic [CFG_W-1:0] ivl_q [NUM_PULSE];
  logic             run_q;
  ref_src_e         sel_q;
  logic             tick;

  // scalar configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      addend_q   <= '0;
      period_q   <= '0;
      prescale_q <= PS_W'(1);
      run_q      <= 1'b0;
      sel_q      <= REF_SYSTEM;
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_W'(ADDR_ADDEND))
        addend_q <= cfg_wdata;
      if (cfg_addr == ADDR_W'(ADDR_PERIOD))
        period_q <= cfg_wdata;
      if (cfg_addr == ADDR_W'(ADDR_PRESCALE))
        prescale_q <= cfg_wdata[PS_W-1:0];
      if (cfg_addr == ADDR_W'(ADDR_CTRL)) begin
        run_q <= cfg_wdata[CTRL_RUN];
        sel_q <= ref_src_e'(cfg_wdata[CTRL_SEL_LSB +: SEL_W]);
      end
    end
  end

  assign ref_sel_o = sel_q;

  tst_rate_acc #(.ACC_W(CFG_W)) acc_i (
    .clk    (clk),
    .rst    (rst),
    .run    (run_q),
    .addend (addend_q),
    .tick   (tick)
  );

  tst_tod #(.TOD_W(TOD_W), .PER_W(CFG_W)) tod_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .period   (period_q),
    .load     (time_we),
    .load_val (time_wdata),
    .tod_q    (tod_o)
  );

  tst_prescaler #(.PS_W(PS_W)) psc_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .restart   (time_we),
    .prescale  (prescale_q),
    .out_clk_o (out_clk_o)
  );

  // one interval register and one generator per pulse output
  for (genvar gi = 0; gi < NUM_PULSE; gi++) begin : g_pulse
    always_ff @(posedge clk) begin
      if (rst)
        ivl_q[gi] <= '0;
      else if (cfg_we && cfg_addr == ADDR_W'(IVL_BASE + gi))
        ivl_q[gi] <= cfg_wdata;
    end

    tst_pulse_gen #(.CNT_W(CFG_W), .PS_W(PS_W)) gen_i (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .restart  (time_we),
      .interval (ivl_q[gi]),
      .period   (period_q),
      .prescale (prescale_q),
      .pulse_o  (pulse_o[gi])
    );
  end
endmodule

// File: rtl/tstamp_timer_chk.sv
`timescale 1ns/1ps
module tstamp_timer_chk #(
  parameter int CFG_W     = 32,
  parameter int TOD_W     = 64,
  parameter int NUM_PULSE = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 time_we,
  input logic [TOD_W-1:0]     time_wdata,
  input logic [TOD_W-1:0]     tod_o,
  input logic                 out_clk_o,
  input logic [NUM_PULSE-1:0] pulse_o,
  input logic [1:0]           ref_sel_o,
  input logic                 run_q,
  input logic                 tick,
  input logic                 cfg_we,
  input logic [CFG_W-1:0]     period_q,
  input logic [CFG_W-1:0]     addend_q
);
  localparam int PAD_W = TOD_W - CFG_W;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (tod_o == '0 && pulse_o == '0 && !out_clk_o && ref_sel_o == 2'd1));

  // R2
  carry_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cfg_we && !addend_q[CFG_W-1]) |=> !tick);

  // R3
  tod_step_chk: assert property (@(posedge clk) disable iff (rst)
    !time_we |=> (tod_o == $past(tod_o) ||
                  tod_o == $past(tod_o) + {{PAD_W{1'b0}}, $past(period_q)}));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !time_we) |=> ($stable(tod_o) && $stable(pulse_o) && $stable(out_clk_o)));

  // R9
  time_load_chk: assert property (@(posedge clk) disable iff (rst)
    time_we |=> (tod_o == $past(time_wdata) && pulse_o == '0));

  // R5
  tick_only_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !time_we) |=> ($stable(out_clk_o) && $stable(pulse_o)));
endmodule

bind tstamp_timer tstamp_timer_chk #(
  .CFG_W(CFG_W), .TOD_W(TOD_W), .NUM_PULSE(NUM_PULSE)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .time_we    (time_we),
  .time_wdata (time_wdata),
  .tod_o      (tod_o),
  .out_clk_o  (out_clk_o),
  .pulse_o    (pulse_o),
  .ref_sel_o  (ref_sel_o),
  .run_q      (run_q),
  .tick       (tick),
  .cfg_we     (cfg_we),
  .period_q   (period_q),
  .addend_q   (addend_q)
);

// File: tb/tstamp_timer_tb_top.sv
`timescale 1ns/1ps
module tstamp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        time_we = 1'b0;
  logic [63:0] time_wdata = '0;
  logic [63:0] tod_o;
  logic        out_clk_o;
  logic [1:0]  pulse_o;
  logic [1:0]  ref_sel_o;

  always #2.5 clk = ~clk;

  tstamp_timer dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .time_we(time_we), .time_wdata(time_wdata),
    .tod_o(tod_o), .out_clk_o(out_clk_o), .pulse_o(pulse_o),
    .ref_sel_o(ref_sel_o)
  );

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // arithmetic model of accumulator and time value (R2 R3 R4 R10)
  logic [31:0] m_acc, m_add, m_per;
  logic [63:0] m_tod;
  logic        m_run;
  logic [32:0] m_sum;
  bit          cmp_on = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_acc = '0; m_add = '0; m_per = '0; m_tod = '0; m_run = 0;
    end else begin
      m_sum = '0;
      if (m_run) begin
        m_sum = {1'b0, m_acc} + {1'b0, m_add};
        m_acc = m_sum[31:0];
      end
      if (time_we) m_tod = time_wdata;
      else if (m_sum[32]) m_tod = m_tod + {32'd0, m_per};
      if (cfg_we) begin
        if (cfg_addr == 3'd0) m_add = cfg_wdata;
        if (cfg_addr == 3'd1) m_per = cfg_wdata;
        if (cfg_addr == 3'd3) m_run = cfg_wdata[0];
      end
    end
  end

  always @(negedge clk)
    if (cmp_on) chk(tod_o == m_tod, "R3", "time value vs model", tod_o, m_tod);

  // pulse monitors (R6 R7) and output clock monitor (R5)
  bit          mon_on = 0;
  logic [63:0] span [2];
  logic [63:0] pwidth;
  logic [63:0] rise_t [2];
  logic [63:0] first_rise [2];
  bit          have [2];
  bit          prev [2];
  int          nrise [2];

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!mon_on) begin
        have[i] = 0; nrise[i] = 0;
      end else begin
        if (pulse_o[i] && !prev[i]) begin
          if (have[i]) chk(tod_o - rise_t[i] == span[i], "R6", "pulse spacing",
                           tod_o - rise_t[i], span[i]);
          else first_rise[i] = tod_o;
          rise_t[i] = tod_o; have[i] = 1; nrise[i]++;
        end
        if (!pulse_o[i] && prev[i] && have[i])
          chk(tod_o - rise_t[i] == pwidth, "R7", "pulse width",
              tod_o - rise_t[i], pwidth);
      end
      prev[i] = pulse_o[i];
    end
  end

  int          clk_mode = 0;  // 0 off, 1 spacing, 2 must stay low
  logic [63:0] oc_span, oc_high, oc_rise;
  bit          oc_have, oc_prev;

  always @(negedge clk) begin
    if (clk_mode == 0) oc_have = 0;
    else if (clk_mode == 2) chk(out_clk_o == 1'b0, "R5", "output clock low", out_clk_o, 0);
    else begin
      if (out_clk_o && !oc_prev) begin
        if (oc_have) chk(tod_o - oc_rise == oc_span, "R5", "output clock period",
                         tod_o - oc_rise, oc_span);
        oc_rise = tod_o; oc_have = 1;
      end
      if (!out_clk_o && oc_prev && oc_have)
        chk(tod_o - oc_rise == oc_high, "R5", "output clock high time",
            tod_o - oc_rise, oc_high);
    end
    oc_prev = out_clk_o;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 0;
  endtask

  task automatic twr(input logic [63:0] v);
    time_we = 1; time_wdata = v;
    step();
    time_we = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] t0, t1, w;
    logic [1:0]  pv;
    bit          oc_s;
    bit          got0, got1, gotc;

    repeat (4) step();
    rst = 0;
    @(negedge clk);
    chk(tod_o == 0, "R1", "reset time", tod_o, 0);
    chk(pulse_o == 0, "R1", "reset pulses", pulse_o, 0);
    chk(out_clk_o == 0, "R1", "reset output clock", out_clk_o, 0);
    chk(ref_sel_o == 2'd1, "R1", "reset source code", ref_sel_o, 1);
    step();
    cmp_on = 1;

    // configuration: T=10, P=4, intervals 110 and 190
    wr(3'd0, 32'h999999A4);
    wr(3'd1, 32'd10);
    wr(3'd2, 32'd4);
    wr(3'd4, 32'd110);
    wr(3'd5, 32'd190);
    repeat (5) step();
    chk(tod_o == 0, "R1", "idle while run is 0", tod_o, 0);
    twr(64'd0);
    span[0] = 120; span[1] = 200; pwidth = 40;
    oc_span = 40; oc_high = 20;
    mon_on = 1; clk_mode = 1;
    wr(3'd3, 32'd3);

    // R2: 3000 running clocks
    t0 = tod_o;
    for (int k = 0; k < 1000; k++) begin
      t1 = tod_o;
      repeat (3) step();
      chk((tod_o - t1) == 10 || (tod_o - t1) == 20, "R2", "ticks per 3 clocks",
          (tod_o - t1) / 10, 2);
    end
    chk(tod_o - t0 == 64'd18000, "R2", "ticks in 3000 clocks", (tod_o - t0) / 10, 1800);
    chk(nrise[0] > 100, "R6", "pulse 0 activity", nrise[0], 100);
    chk(nrise[1] > 60, "R6", "pulse 1 activity", nrise[1], 60);

    // R4: addend change while running
    wr(3'd0, 32'h4000_0000);
    t0 = tod_o;
    repeat (400) step();
    chk(tod_o - t0 == 64'd1000, "R4", "quarter-rate ticks in 400 clocks",
        (tod_o - t0) / 10, 100);

    // R8: freeze
    wr(3'd3, 32'd2);
    t0 = tod_o; pv = pulse_o; oc_s = out_clk_o;
    repeat (50) step();
    chk(tod_o == t0, "R8", "time frozen", tod_o, t0);
    chk(pulse_o == pv, "R8", "pulses frozen", pulse_o, pv);
    chk(out_clk_o == oc_s, "R8", "output clock frozen", out_clk_o, oc_s);
    wr(3'd0, 32'h999999A4);
    wr(3'd3, 32'd3);
    repeat (20) step();

    // R9: time load restarts prescaler and pulse generators
    mon_on = 0; clk_mode = 0;
    step();
    w = 64'd5000;
    twr(w);
    chk(tod_o == w, "R9", "loaded time", tod_o, w);
    chk(pulse_o == 0, "R9", "pulses low after load", pulse_o, 0);
    chk(out_clk_o == 1, "R9", "output clock restarted high", out_clk_o, 1);
    got0 = 0; got1 = 0; gotc = 0;
    for (int k = 0; k < 600 && !(got0 && got1 && gotc); k++) begin
      pv = pulse_o; oc_s = out_clk_o;
      step();
      if (pulse_o[0] && !pv[0] && !got0) begin
        got0 = 1; chk(tod_o == w + 120, "R9", "first pulse 0", tod_o, w + 120);
      end
      if (pulse_o[1] && !pv[1] && !got1) begin
        got1 = 1; chk(tod_o == w + 200, "R9", "first pulse 1", tod_o, w + 200);
      end
      if (!out_clk_o && oc_s && !gotc) begin
        gotc = 1; chk(tod_o == w + 20, "R9", "first clock fall", tod_o, w + 20);
      end
    end
    chk(got0 && got1 && gotc, "R9", "edges seen after load", {got0, got1, gotc}, 7);

    // R10: wrap
    twr(64'hFFFF_FFFF_FFFF_FFD8);
    repeat (30) step();
    chk(tod_o < 64'd1000, "R10", "time wrapped", tod_o, 140);

    // R11: one pulse per second, period 1e8, prescale 1
    wr(3'd3, 32'd2);
    wr(3'd1, 32'd100_000_000);
    wr(3'd2, 32'd1);
    wr(3'd4, 32'd900_000_000);
    wr(3'd5, 32'd100_000_000);
    span[0] = 64'd1_000_000_000; span[1] = 64'd200_000_000; pwidth = 64'd100_000_000;
    twr(64'd0);
    mon_on = 1; clk_mode = 2;
    wr(3'd3, 32'd3);
    repeat (400) step();
    chk(nrise[0] >= 20, "R11", "second pulses seen", nrise[0], 20);
    chk(first_rise[0] == 64'd1_000_000_000, "R11", "first second pulse",
        first_rise[0], 64'd1_000_000_000);

    // R12: source code field
    wr(3'd3, 32'd5);
    chk(ref_sel_o == 2'd2, "R12", "source code 2", ref_sel_o, 2);
    t0 = tod_o;
    repeat (10) step();
    chk(tod_o != t0, "R12", "run still set", tod_o, t0);
    wr(3'd3, 32'd7);
    chk(ref_sel_o == 2'd3, "R12", "source code 3", ref_sel_o, 3);
    wr(3'd3, 32'd0);
    chk(ref_sel_o == 2'd0, "R12", "source code 0 with run clear", ref_sel_o, 0);
    repeat (5) step();

    done = 1;
    summary();
    $finish;
  end
endmodule